// File: doc/BRIEF.md
# USB Device Attach and Bus-Reset Controller

This block owns the attach state of a full-speed USB device and its reaction to a bus reset from the host. Software attaches the device by setting a soft-connect bit. That enables the D+/D- output drivers. The block then watches the line pair and ignores everything on it until it sees a bus reset. A reset is SE0 (both lines low) held for a parameterised number of clock cycles. When a reset is recognised, the block does the following:

- clears the function address, the endpoint index and the per-endpoint halt bits;
- turns on every endpoint interrupt enable;
- sends a one-cycle flush strobe to each endpoint FIFO;
- latches a sticky reset interrupt flag.

The block also detects the end of a session and raises a flag for it. A session ends either when SE0 lasts past a second, longer threshold, or when VBUS valid drops while the device is connected. Attaching through soft-connect raises no flag. Status flags stay set until the status register is read. The `irq` output is high while any flag is set together with its enable.

The control state machine has five states:

| State | Meaning |
|---|---|
| `ST_DETACHED` | Drivers off. |
| `ST_WAIT_RESET` | Drivers on, all signalling ignored except a reset. |
| `ST_IN_RESET` | SE0 continues after a reset has been recognised. |
| `ST_ACTIVE` | Reset finished, device ready for traffic. |
| `ST_SESS_END` | The session has ended. |

The transitions are:

| Name | From | To | Condition |
|---|---|---|---|
| attach | `ST_DETACHED` | `ST_WAIT_RESET` | soft-connect is 1 |
| reset-hit | `ST_WAIT_RESET` or `ST_ACTIVE` | `ST_IN_RESET` | the SE0 run reaches `RST_CYC` |
| reset-release | `ST_IN_RESET` | `ST_ACTIVE` | SE0 ends |
| session-end | any connected state | `ST_SESS_END` | the SE0 run reaches `SESS_CYC`, or VBUS valid drops |
| recover | `ST_SESS_END` | `ST_WAIT_RESET` | VBUS valid is 1 and the line is not SE0 |
| detach | any state | `ST_DETACHED` | soft-connect is 0 |

Top module: `usb_attach_ctrl`

## Requirements

The register map (3-bit address, 8-bit data) is:

| Address | Content | Value after `rst_n` |
|---|---|---|
| 0 | bit0 = soft-connect | 0 |
| 1 | [6:0] = function address | 0 |
| 2 | [3:0] = endpoint index | 0 |
| 3 | bit0 = reset interrupt enable, bit1 = session-end interrupt enable | 0 |
| 4 | status, same bit layout as address 3; read-to-clear | 0 |
| 5 | [NUM_EP-1:0] = endpoint interrupt enables | 0 |
| 6 | [NUM_EP-1:0] = endpoint halt bits | 0 |

- R1: After `rst_n`, soft-connect (address 0, bit0) reads 0, `drv_oe` and `bus_ready` are 0, the status register (address 4) reads 0 and `irq` is 0.
- R2: Writing 1 to soft-connect raises `drv_oe` on the second clock edge after the write is presented. Writing 0 drops `drv_oe` and `bus_ready` with the same timing.
- R3: After attach, J, K and SE0 runs shorter than `RST_CYC` cycles leave `bus_ready` at 0 and the status register at 0.
- R4: A bus reset is recognised on the `RST_CYC`-th consecutive clock edge that samples SE0 while soft-connect is 1. SE0 of any length while soft-connect is 0 has no effect.
- R5: A bus reset clears the function address, the endpoint index and all endpoint halt bits, and sets every endpoint interrupt enable.
- R6: Every bit of `fifo_flush` is high for exactly the one cycle that follows the detecting edge, and is low at all other times.
- R7: A bus reset sets status bit0. Attaching through soft-connect sets no status bit.
- R8: A session end sets status bit1 and moves the block to `ST_SESS_END`, where `bus_ready` is 0. A session end is either SE0 for `SESS_CYC` consecutive edges or VBUS valid low while connected. The block leaves `ST_SESS_END` once VBUS valid is 1 and the line is not SE0.
- R9: Status bits are sticky and are cleared by a read of address 4. If a flag is set in the same cycle as a read, the set wins.
- R10: `irq` equals the OR over both status bits of (status AND enable).
- R11: A register write that coincides with the detecting edge of a bus reset has no effect on the fields that the reset clears.
- R12: When SE0 ends after a bus reset, `bus_ready` rises on the next edge.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read clears status) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| line_dp | input | 1 | Received D+ level |
| line_dm | input | 1 | Received D- level |
| vbus_valid | input | 1 | VBUS present |
| drv_oe | output | 1 | D+/D- driver enable |
| bus_ready | output | 1 | Device reset and ready for traffic |
| func_addr | output | 7 | Function address |
| ep_index | output | 4 | Endpoint index |
| ep_irq_en | output | NUM_EP | Endpoint interrupt enables |
| ep_halt | output | NUM_EP | Endpoint halt bits |
| fifo_flush | output | NUM_EP | Per-endpoint FIFO flush strobe |
| irq | output | 1 | Interrupt request |

## Verification

Two kinds of collision can fall in one cycle.

- **Status read and reset detection.** Software can read the status register on the very edge at which a bus reset is detected. The bench provokes this by holding SE0 for `RST_CYC - 1` edges and then presenting the status read in the cycle before the detecting edge. The check passes only if the reset flag still reads 1 afterwards.
- **Register write and reset detection.** A write to the function address can coincide with the detecting edge. The bench provokes this the same way and expects the function address to read 0 afterwards.

SE0 run lengths are swept from 1 to past the session threshold. The expected status value for each length is computed arithmetically in the bench.

// File: rtl/usb_attach_pkg.sv
package usb_attach_pkg;

    typedef enum logic [2:0] {
        ST_DETACHED   = 3'd0,
        ST_WAIT_RESET = 3'd1,
        ST_IN_RESET   = 3'd2,
        ST_ACTIVE     = 3'd3,
        ST_SESS_END   = 3'd4
    } link_state_t;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_FADDR  = 3'd1;
    localparam logic [2:0] A_EPIDX  = 3'd2;
    localparam logic [2:0] A_BUSIE  = 3'd3;
    localparam logic [2:0] A_BUSSTS = 3'd4;
    localparam logic [2:0] A_EPIE   = 3'd5;
    localparam logic [2:0] A_EPHALT = 3'd6;

    localparam int FLAG_RESET = 0;
    localparam int FLAG_SESS  = 1;

endpackage

// File: rtl/usb_link_fsm.sv
module usb_link_fsm
    import usb_attach_pkg::*;
#(
    parameter int RST_CYC  = 120,
    parameter int SESS_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_conn,
    input  logic line_dp,
    input  logic line_dm,
    input  logic vbus_valid,
    output logic drv_oe,
    output logic bus_ready,
    output logic bus_reset_evt,
    output logic sess_end_evt
);
    localparam int CW = $clog2(SESS_CYC + 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] SESS_LAST = CW'(SESS_CYC - 1);

    link_state_t state_q, state_d;
    logic [CW-1:0] se0_cnt_q;
    logic se0;

    assign se0 = !line_dp && !line_dm;

    // Length of the current SE0 run, saturating at the session threshold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            se0_cnt_q <= '0;
        else if (!soft_conn || !se0)
            se0_cnt_q <= '0;
        else if (se0_cnt_q != SESS_LAST)
            se0_cnt_q <= se0_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DETACHED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        bus_reset_evt = 1'b0;
        sess_end_evt  = 1'b0;
        if (!soft_conn) begin
            state_d = ST_DETACHED;
        end else begin
            unique case (state_q)
                ST_DETACHED: state_d = ST_WAIT_RESET;
                ST_WAIT_RESET, ST_ACTIVE: begin
                    if (!vbus_valid) begin
                        sess_end_evt = 1'b1;
                        state_d      = ST_SESS_END;
                    end else if (se0 && se0_cnt_q == RST_LAST) begin
                        bus_reset_evt = 1'b1;
                        state_d       = ST_IN_RESET;
                    end
                end
                ST_IN_RESET: begin
                    if (!vbus_valid || (se0 && se0_cnt_q == SESS_LAST)) begin
                        sess_end_evt = 1'b1;
                        state_d      = ST_SESS_END;
                    end else if (!se0) begin
                        state_d = ST_ACTIVE;
                    end
                end
                ST_SESS_END: begin
                    if (vbus_valid && !se0) state_d = ST_WAIT_RESET;
                end
                default: state_d = ST_DETACHED;
            endcase
        end
    end

    always_comb begin
        drv_oe    = (state_q != ST_DETACHED);
        bus_ready = (state_q == ST_ACTIVE);
    end

    // R3: while waiting for the first reset, nothing but a reset leaves the wait
    a_r3_wait_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RESET && !bus_reset_evt) |=> (state_q != ST_ACTIVE));

    // R4: a reset is only detected after SE0 was already present (needs RST_CYC >= 2)
    a_r4_se0_history: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |-> (se0 && $past(se0) && $past(soft_conn)));

    // R8: a session end always lands in the session-end state
    a_r8_sess_state: assert property (@(posedge clk) disable iff (!rst_n)
        sess_end_evt |=> (state_q == ST_SESS_END || !$past(soft_conn)));

    initial begin
        a_r4_thresholds: assert (RST_CYC >= 2 && SESS_CYC > RST_CYC);
    end
endmodule

// File: rtl/usb_attach_regs.sv
module usb_attach_regs
    import usb_attach_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bus_reset_evt,
    input  logic              sess_end_evt,
    output logic              soft_conn,
    output logic [6:0]        func_addr,
    output logic [3:0]        ep_index,
    output logic [NUM_EP-1:0] ep_irq_en,
    output logic [NUM_EP-1:0] ep_halt,
    output logic              irq
);
    logic [1:0] bus_ie_q, sts_q, sts_set;
    logic       wr_ctrl, wr_faddr, wr_epidx, wr_busie, wr_epie, wr_ephalt, rd_sts;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata;

    assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
    assign wr_faddr  = reg_wr && reg_addr == A_FADDR;
    assign wr_epidx  = reg_wr && reg_addr == A_EPIDX;
    assign wr_busie  = reg_wr && reg_addr == A_BUSIE;
    assign wr_epie   = reg_wr && reg_addr == A_EPIE;
    assign wr_ephalt = reg_wr && reg_addr == A_EPHALT;
    assign rd_sts    = reg_rd && reg_addr == A_BUSSTS;

    always_comb begin
        sts_set             = '0;
        sts_set[FLAG_RESET] = bus_reset_evt;
        sts_set[FLAG_SESS]  = sess_end_evt;
    end

    // Soft-connect and bus interrupt enables survive a bus reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_conn <= 1'b0;
            bus_ie_q  <= '0;
        end else begin
            if (wr_ctrl)  soft_conn <= reg_wdata[0];
            if (wr_busie) bus_ie_q  <= reg_wdata[1:0];
        end
    end

    // Device state: a bus reset takes priority over a write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_addr <= '0;
            ep_index  <= '0;
        end else if (bus_reset_evt) begin
            func_addr <= '0;
            ep_index  <= '0;
        end else begin
            if (wr_faddr) func_addr <= reg_wdata[6:0];
            if (wr_epidx) ep_index  <= reg_wdata[3:0];
        end
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ep_irq_en[e] <= 1'b0;
                ep_halt[e]   <= 1'b0;
            end else if (bus_reset_evt) begin
                ep_irq_en[e] <= 1'b1;
                ep_halt[e]   <= 1'b0;
            end else begin
                if (wr_epie)   ep_irq_en[e] <= reg_wdata[e];
                if (wr_ephalt) ep_halt[e]   <= reg_wdata[e];
            end
        end
    end

    // Sticky flags: read clears, a same-cycle set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (rd_sts ? 2'b00 : sts_q) | sts_set;
    end

    assign irq = |(sts_q & bus_ie_q);

    always_comb begin
        unique case (reg_addr)
            A_CTRL:   reg_rdata = {7'd0, soft_conn};
            A_FADDR:  reg_rdata = {1'b0, func_addr};
            A_EPIDX:  reg_rdata = {4'd0, ep_index};
            A_BUSIE:  reg_rdata = {6'd0, bus_ie_q};
            A_BUSSTS: reg_rdata = {6'd0, sts_q};
            A_EPIE:   reg_rdata = 8'(ep_irq_en);
            A_EPHALT: reg_rdata = 8'(ep_halt);
            default:  reg_rdata = 8'd0;
        endcase
    end

    // R5 / R11: reset clears device state whatever else happened that cycle
    a_r5_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> (func_addr == 7'd0 && ep_index == 4'd0 &&
                           ep_halt == '0 && ep_irq_en == '1));

    // R9 / R7: reset flag is set even when a status read coincides
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> sts_q[FLAG_RESET]);

    // R8: session end sets its flag
    a_r8_sess_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sess_end_evt |=> sts_q[FLAG_SESS]);

    // R9: flags only rise through an event
    a_r9_sticky_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[FLAG_RESET]) |-> $past(bus_reset_evt));

    initial begin
        a_r5_ep_fit: assert (NUM_EP >= 1 && NUM_EP <= 8);
    end
endmodule

// File: rtl/usb_fifo_flush.sv
module usb_fifo_flush #(
    parameter int NUM_EP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset_evt,
    output logic [NUM_EP-1:0] fifo_flush
);
    logic flush_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= bus_reset_evt;
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_flush
        assign fifo_flush[e] = flush_q;
    end

    // R6: a strobe follows every detection
    a_r6_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> fifo_flush[0]);

    // R6: the strobe lasts one cycle (two detections cannot be adjacent)
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush[0] |=> !fifo_flush[0]);
endmodule

// File: rtl/usb_attach_ctrl.sv
module usb_attach_ctrl #(
    parameter int NUM_EP   = 4,
    parameter int RST_CYC  = 120,
    parameter int SESS_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              line_dp,
    input  logic              line_dm,
    input  logic              vbus_valid,
    output logic              drv_oe,
    output logic              bus_ready,
    output logic [6:0]        func_addr,
    output logic [3:0]        ep_index,
    output logic [NUM_EP-1:0] ep_irq_en,
    output logic [NUM_EP-1:0] ep_halt,
    output logic [NUM_EP-1:0] fifo_flush,
    output logic              irq
);
    logic soft_conn, bus_reset_evt, sess_end_evt;

    usb_attach_regs #(.NUM_EP(NUM_EP)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_reset_evt(bus_reset_evt), .sess_end_evt(sess_end_evt),
        .soft_conn(soft_conn), .func_addr(func_addr), .ep_index(ep_index),
        .ep_irq_en(ep_irq_en), .ep_halt(ep_halt), .irq(irq)
    );

    usb_link_fsm #(.RST_CYC(RST_CYC), .SESS_CYC(SESS_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_conn(soft_conn),
        .line_dp(line_dp), .line_dm(line_dm), .vbus_valid(vbus_valid),
        .drv_oe(drv_oe), .bus_ready(bus_ready),
        .bus_reset_evt(bus_reset_evt), .sess_end_evt(sess_end_evt)
    );

    usb_fifo_flush #(.NUM_EP(NUM_EP)) u_flush (
        .clk(clk), .rst_n(rst_n), .bus_reset_evt(bus_reset_evt),
        .fifo_flush(fifo_flush)
    );

    // R2: with soft-connect low the drivers are off on the next edge
    a_r2_detach: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_conn |=> !drv_oe);

    // R4: no reset detection while detached
    a_r4_detached_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_conn |=> !fifo_flush[0]);
endmodule

// File: tb/usb_attach_ctrl_bench.sv
`timescale 1ns/1ps
module usb_attach_ctrl_bench;
    localparam int NEP  = 4;
    localparam int RSTC = 4;
    localparam int SESC = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic line_dp = 1'b1, line_dm = 1'b0, vbus_valid = 1'b1;
    logic drv_oe, bus_ready, irq;
    logic [6:0] func_addr;
    logic [3:0] ep_index;
    logic [NEP-1:0] ep_irq_en, ep_halt, fifo_flush;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    usb_attach_ctrl #(.NUM_EP(NEP), .RST_CYC(RSTC), .SESS_CYC(SESC)) u_usb_attach_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_dp(line_dp), .line_dm(line_dm), .vbus_valid(vbus_valid),
        .drv_oe(drv_oe), .bus_ready(bus_ready), .func_addr(func_addr),
        .ep_index(ep_index), .ep_irq_en(ep_irq_en), .ep_halt(ep_halt),
        .fifo_flush(fifo_flush), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // SE0 for n edges, then J
    task automatic se0_run(int n);
        line_dp = 1'b0; line_dm = 1'b0;
        tick(n);
        line_dp = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 drv_oe", int'(drv_oe), 0);
        chk("R1 bus_ready", int'(bus_ready), 0);
        chk("R1 irq", int'(irq), 0);
        rd(3'd0, v); chk("R1 softconn", v, 0);
        rd(3'd4, v); chk("R1 status", v, 0);

        // R4 SE0 while detached is ignored
        se0_run(3 * SESC);
        rd(3'd4, v); chk("R4 detached SE0 status", v, 0);
        chk("R4 detached flush", int'(fifo_flush), 0);

        // R7 attach raises no flag, R2 drivers follow
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h01);
        chk("R2 oe lag", int'(drv_oe), 0);
        tick(1);
        chk("R2 drv_oe on", int'(drv_oe), 1);
        chk("R7 no irq on attach", int'(irq), 0);
        rd(3'd4, v); chk("R7 no flag on attach", v, 0);

        // R3 sweep of non-reset signalling while waiting
        for (int p = 0; p < RSTC + 1; p++) begin
            if (p == 0) begin line_dp = 1'b0; line_dm = 1'b1; tick(5); line_dp = 1'b1; line_dm = 1'b0; end
            else if (p < RSTC) se0_run(p);
            else tick(5);
            tick(1);
            chk($sformatf("R3 ready pattern %0d", p), int'(bus_ready), 0);
            rd(3'd4, v); chk($sformatf("R3 status pattern %0d", p), v, 0);
        end

        // load state that a reset must clear
        wr(3'd1, 8'h55); wr(3'd2, 8'h03); wr(3'd6, 8'h0F); wr(3'd5, 8'h00);
        rd(3'd1, v); chk("R5 faddr preload", v, 8'h55);

        // R4/R6 detection edge and strobe width
        line_dp = 1'b0; line_dm = 1'b0;
        for (int k = 1; k < RSTC; k++) begin
            tick(1);
            chk($sformatf("R6 no early flush %0d", k), int'(fifo_flush), 0);
        end
        tick(1);
        chk("R6 flush high", int'(fifo_flush), 4'hF);
        tick(1);
        chk("R6 flush one cycle", int'(fifo_flush), 0);
        chk("R12 not ready during SE0", int'(bus_ready), 0);
        line_dp = 1'b1;
        tick(1);
        chk("R12 ready after release", int'(bus_ready), 1);
        chk("R5 faddr port", int'(func_addr), 0);
        chk("R5 epidx port", int'(ep_index), 0);
        chk("R5 halt port", int'(ep_halt), 0);
        chk("R5 ep ie port", int'(ep_irq_en), 4'hF);
        chk("R10 irq on reset", int'(irq), 1);
        rd(3'd4, v); chk("R7 reset flag", v, 1);
        rd(3'd4, v); chk("R9 read clears", v, 0);
        chk("R10 irq after clear", int'(irq), 0);

        // near-exhaustive SE0 length sweep in the active state
        for (int len = 1; len <= SESC + 2; len++) begin
            se0_run(len);
            tick(1);
            chk($sformatf("R8 ready len %0d", len), int'(bus_ready), (len < SESC) ? 1 : 0);
            rd(3'd4, v);
            chk($sformatf("R4 R8 status len %0d", len), v,
                ((len >= SESC) ? 2 : 0) + ((len >= RSTC) ? 1 : 0));
            if (len >= SESC) begin
                se0_run(RSTC); tick(1);
                rd(3'd4, v); chk("R8 recover reset", v, 1);
            end
        end

        // R8 VBUS drop
        vbus_valid = 1'b0; tick(1); vbus_valid = 1'b1; tick(1);
        chk("R8 vbus ready", int'(bus_ready), 0);
        rd(3'd4, v); chk("R8 vbus flag", v, 2);
        se0_run(RSTC); tick(1);
        rd(3'd4, v); chk("R8 recover after vbus", v, 1);

        // R10 enable sweep with both flags set
        se0_run(SESC); tick(1);
        for (int ie = 0; ie < 4; ie++) begin
            wr(3'd3, 8'(ie));
            chk($sformatf("R10 irq ie %0d", ie), int'(irq), (ie != 0) ? 1 : 0);
        end
        rd(3'd4, v); chk("R9 both sticky", v, 3);
        se0_run(RSTC); tick(1);
        rd(3'd4, v);

        // R9 status read in the detecting cycle
        line_dp = 1'b0; line_dm = 1'b0;
        tick(RSTC - 1);
        reg_addr = 3'd4; reg_rd = 1'b1;
        #1 v = int'(reg_rdata);
        chk("R9 pre-read empty", v, 0);
        @(negedge clk); reg_rd = 1'b0;
        line_dp = 1'b1; tick(1);
        rd(3'd4, v); chk("R9 set wins over read", v, 1);

        // R11 write in the detecting cycle
        wr(3'd1, 8'h33);
        rd(3'd1, v); chk("R11 faddr before", v, 8'h33);
        line_dp = 1'b0; line_dm = 1'b0;
        tick(RSTC - 1);
        wr(3'd1, 8'h2A);
        line_dp = 1'b1; tick(1);
        rd(3'd1, v); chk("R11 reset wins over write", v, 0);
        rd(3'd4, v);

        // R2 detach
        wr(3'd0, 8'h00);
        tick(1);
        chk("R2 drv_oe off", int'(drv_oe), 0);
        chk("R2 ready off", int'(bus_ready), 0);
        se0_run(SESC + 2);
        rd(3'd4, v); chk("R4 SE0 after detach", v, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule